// File: doc/BRIEF.md
# Peripheral Access Gate

This block stands between one bus master and up to 64 peripheral slots. Each slot is selected by a peripheral ID. Every request carries that ID, a privilege bit and a bit that tells which address alias was used (secure or non-secure). The gate checks the request against two attribute maps kept in its own register block.

The first map marks slots that only privileged code may reach. The second marks slots that are secure and must be reached through the secure alias. A request that breaks either rule never reaches the peripheral. Such a blocked write is dropped, and a blocked read returns zero. The offence sets a sticky flag, one flag for privilege faults and another for alias faults. The gate also latches the peripheral ID of the first offence. Each flag, ANDed with its enable bit, drives an interrupt line.

The gate's own register block answers at a fixed slot ID (default 45). It goes through the same check, so unprivileged code cannot change the protection setup when that slot is marked privileged-only.

Fault capture is a two-state machine:
- **CAP_OPEN**: no fault ID is held. Any fault moves it to CAP_HELD and loads the ID.
- **CAP_HELD**: the first ID is kept. The machine returns to CAP_OPEN in the cycle that leaves both flags clear.

Top module: `acc_guard`

## Requirements
- R1: When protection is on and a slot's privileged-only bit is set, a request with `m_priv`=0 to that slot keeps `p_req` and `p_we` low, so no register of the peripheral is read or written.
- R2: A blocked read drives `m_rdata` to all zeros.
- R3: The privileged-only bits sit in two words: offset 1 holds IDs 0–31 (ID k at bit k), and offset 2 holds IDs 32–63 (ID 32+n at bit n).
- R4: Bit 0 of the control word at offset 0 turns protection on. It is 0 after reset, and while it is 0 every request passes through.
- R5: A privilege fault sets flag bit 0 of the flag word (offset 5) and writes the slot ID to the fault-ID word (offset 10). Both are visible after the clock edge of the faulting request.
- R6: The secure bits sit at offsets 3 and 4, laid out as in R3. A request whose `m_sec` differs from the slot's secure bit is blocked, sets flag bit 1 and latches the slot ID.
- R7: Flags stay set until software clears them. While the machine is in CAP_HELD, later faults leave the fault-ID word unchanged.
- R8: `irq_priv` equals flag bit 0 AND enable bit 0, and `irq_sec` equals flag bit 1 AND enable bit 1. The enables are at offset 8. Offset 9 reads flags AND enables, and reading it changes no flag.
- R9: Writing a mask to offset 6 sets those flag bits, and writing a mask to offset 7 clears them. Writing the enables at offset 8 leaves pending flags untouched.
- R10: A single request that breaks both rules sets both flags and records one ID.
- R11: The register block at slot ID 45 obeys the same checks. A blocked write to it changes no configuration.
- R12: The decision is combinational in the request cycle, so a blocked write never shows `p_we`=1. Fault flags update on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 1 | Master request valid |
| m_we | input | 1 | Master write (1) or read (0) |
| m_priv | input | 1 | Request comes from privileged code |
| m_sec | input | 1 | Request used the secure alias |
| m_pid | input | 6 | Target slot ID |
| m_addr | input | 4 | Word offset inside the slot |
| m_wdata | input | 32 | Write data |
| m_rdata | output | 32 | Read data, zero when the request is blocked |
| p_req | output | 1 | Forwarded request to the peripherals |
| p_we | output | 1 | Forwarded write strobe |
| p_pid | output | 6 | Forwarded slot ID |
| p_addr | output | 4 | Forwarded word offset |
| p_wdata | output | 32 | Forwarded write data |
| p_rdata | input | 32 | Peripheral read data |
| irq_priv | output | 1 | Privilege-fault interrupt |
| irq_sec | output | 1 | Alias-fault interrupt |

## Verification
The assertions assume that the master finishes each request in one cycle. They also assume that a register write and a fault can never meet in one cycle, because a write that reaches the register block is by definition not blocked. The set/clear arbitration therefore never meets a simultaneous hardware fault. The bench issues exactly one request per cycle from a task, with `m_req` low between requests. It reaches the register block only with privileged, non-secure-alias requests, except in the R11 scenario, where the block is deliberately protected.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    localparam int NSLOT_DEF = 64;
    localparam int DW_DEF    = 32;
    localparam int RAW_DEF   = 4;
    localparam int SELF_DEF  = 45;

    localparam int NFLAG   = 2;
    localparam int FB_PRIV = 0;
    localparam int FB_SEC  = 1;

    typedef enum logic [0:0] {
        CAP_OPEN = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic sec_f;
        logic priv_f;
    } fault_t;

endpackage

// File: rtl/acc_guard_check.sv
module acc_guard_check
    import acc_guard_pkg::*;
#(
    parameter int NSLOT = NSLOT_DEF,
    localparam int PID_W = $clog2(NSLOT)
) (
    input  logic             en,
    input  logic             req,
    input  logic             priv,
    input  logic             sec,
    input  logic [PID_W-1:0] pid,
    input  logic [NSLOT-1:0] priv_map,
    input  logic [NSLOT-1:0] sec_map,
    output fault_t           flt
);

    logic need_priv;
    logic slot_sec;

    always_comb begin
        need_priv  = priv_map[pid];
        slot_sec   = sec_map[pid];
        flt.priv_f = en & req & need_priv & ~priv;
        flt.sec_f  = en & req & (slot_sec ^ sec);
    end

endmodule

// File: rtl/acc_guard_regs.sv
module acc_guard_regs
    import acc_guard_pkg::*;
#(
    parameter int NSLOT = NSLOT_DEF,
    parameter int DW    = DW_DEF,
    parameter int RAW   = RAW_DEF,
    localparam int PID_W = $clog2(NSLOT),
    localparam int WORDS = (NSLOT + DW - 1) / DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RAW-1:0]   addr,
    input  logic [DW-1:0]    wdata,
    input  fault_t           flt,
    input  logic [PID_W-1:0] pid,
    output logic [DW-1:0]    rdata,
    output logic             prot_en,
    output logic [NSLOT-1:0] priv_map,
    output logic [NSLOT-1:0] sec_map,
    output logic [NFLAG-1:0] irq
);

    localparam int OFS_CTRL = 0;
    localparam int OFS_PRIV = 1;
    localparam int OFS_SEC  = OFS_PRIV + WORDS;
    localparam int OFS_FLAG = OFS_SEC + WORDS;
    localparam int OFS_FSET = OFS_FLAG + 1;
    localparam int OFS_FCLR = OFS_FLAG + 2;
    localparam int OFS_IEN  = OFS_FLAG + 3;
    localparam int OFS_PEND = OFS_FLAG + 4;
    localparam int OFS_FID  = OFS_FLAG + 5;

    logic [WORDS-1:0][DW-1:0] priv_w;
    logic [WORDS-1:0][DW-1:0] sec_w;
    logic [WORDS*DW-1:0]      priv_flat;
    logic [WORDS*DW-1:0]      sec_flat;
    logic                     ctrl_en;
    logic [NFLAG-1:0]         flags;
    logic [NFLAG-1:0]         flag_nxt;
    logic [NFLAG-1:0]         ien;
    logic [PID_W-1:0]         fid;
    cap_state_e               state;
    cap_state_e               state_nxt;
    logic                     fault_any;
    logic                     load_id;

    assign fault_any = flt.priv_f | flt.sec_f;

    // attribute words, one pair per group of DW slots
    for (genvar w = 0; w < WORDS; w++) begin : g_attr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                priv_w[w] <= '0;
                sec_w[w]  <= '0;
            end else if (wr_en) begin
                if (addr == RAW'(OFS_PRIV + w)) priv_w[w] <= wdata;
                if (addr == RAW'(OFS_SEC + w))  sec_w[w]  <= wdata;
            end
        end
    end

    assign priv_flat = priv_w;
    assign sec_flat  = sec_w;
    assign priv_map  = priv_flat[NSLOT-1:0];
    assign sec_map   = sec_flat[NSLOT-1:0];
    assign prot_en   = ctrl_en;
    assign irq       = flags & ien;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            ien     <= '0;
        end else if (wr_en) begin
            if (addr == RAW'(OFS_CTRL)) ctrl_en <= wdata[0];
            if (addr == RAW'(OFS_IEN))  ien     <= wdata[NFLAG-1:0];
        end
    end

    // flag update: software set/clear, then hardware faults win
    always_comb begin
        flag_nxt = flags;
        if (wr_en && addr == RAW'(OFS_FSET)) flag_nxt = flag_nxt | wdata[NFLAG-1:0];
        if (wr_en && addr == RAW'(OFS_FCLR)) flag_nxt = flag_nxt & ~wdata[NFLAG-1:0];
        flag_nxt[FB_PRIV] = flag_nxt[FB_PRIV] | flt.priv_f;
        flag_nxt[FB_SEC]  = flag_nxt[FB_SEC]  | flt.sec_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= flag_nxt;
    end

    // capture state machine: next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CAP_OPEN: if (fault_any)        state_nxt = CAP_HELD;
            CAP_HELD: if (flag_nxt == '0)   state_nxt = CAP_OPEN;
            default:                        state_nxt = CAP_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_OPEN;
        else        state <= state_nxt;
    end

    // capture state machine: outputs
    always_comb begin
        load_id = 1'b0;
        unique case (state)
            CAP_OPEN: load_id = fault_any;
            CAP_HELD: load_id = 1'b0;
            default:  load_id = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fid <= '0;
        else if (load_id) fid <= pid;
    end

    always_comb begin
        rdata = '0;
        if (addr == RAW'(OFS_CTRL)) rdata[0] = ctrl_en;
        for (int w = 0; w < WORDS; w++) begin
            if (addr == RAW'(OFS_PRIV + w)) rdata = priv_w[w];
            if (addr == RAW'(OFS_SEC + w))  rdata = sec_w[w];
        end
        if (addr == RAW'(OFS_FLAG)) rdata[NFLAG-1:0] = flags;
        if (addr == RAW'(OFS_IEN))  rdata[NFLAG-1:0] = ien;
        if (addr == RAW'(OFS_PEND)) rdata[NFLAG-1:0] = flags & ien;
        if (addr == RAW'(OFS_FID))  rdata[PID_W-1:0] = fid;
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flt.priv_f |=> flags[FB_PRIV] && state == CAP_HELD);

    p_sec_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flt.sec_f |=> flags[FB_SEC]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FB_PRIV] && !(wr_en && addr == RAW'(OFS_FCLR) && wdata[FB_PRIV])
        |=> flags[FB_PRIV]);

    p_id_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == CAP_HELD |=> $stable(fid));

    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt.priv_f && ien[FB_PRIV] |=> irq[FB_PRIV]);

    p_ien_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == RAW'(OFS_IEN) |=> flags == $past(flags));

    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flt.priv_f && flt.sec_f |=> flags == 2'b11);

endmodule

// File: rtl/acc_guard.sv
module acc_guard
    import acc_guard_pkg::*;
#(
    parameter int NSLOT   = NSLOT_DEF,
    parameter int DW      = DW_DEF,
    parameter int RAW     = RAW_DEF,
    parameter int SELF_ID = SELF_DEF,
    localparam int PID_W  = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req,
    input  logic             m_we,
    input  logic             m_priv,
    input  logic             m_sec,
    input  logic [PID_W-1:0] m_pid,
    input  logic [RAW-1:0]   m_addr,
    input  logic [DW-1:0]    m_wdata,
    output logic [DW-1:0]    m_rdata,
    output logic             p_req,
    output logic             p_we,
    output logic [PID_W-1:0] p_pid,
    output logic [RAW-1:0]   p_addr,
    output logic [DW-1:0]    p_wdata,
    input  logic [DW-1:0]    p_rdata,
    output logic             irq_priv,
    output logic             irq_sec
);

    fault_t           flt;
    logic             prot_en;
    logic [NSLOT-1:0] priv_map;
    logic [NSLOT-1:0] sec_map;
    logic [NFLAG-1:0] irq;
    logic [DW-1:0]    reg_rdata;
    logic             to_self;
    logic             blocked;
    logic             reg_wr;

    acc_guard_check #(.NSLOT(NSLOT)) u_check (
        .en       (prot_en),
        .req      (m_req),
        .priv     (m_priv),
        .sec      (m_sec),
        .pid      (m_pid),
        .priv_map (priv_map),
        .sec_map  (sec_map),
        .flt      (flt)
    );

    acc_guard_regs #(.NSLOT(NSLOT), .DW(DW), .RAW(RAW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (m_addr),
        .wdata    (m_wdata),
        .flt      (flt),
        .pid      (m_pid),
        .rdata    (reg_rdata),
        .prot_en  (prot_en),
        .priv_map (priv_map),
        .sec_map  (sec_map),
        .irq      (irq)
    );

    assign to_self  = (m_pid == PID_W'(SELF_ID));
    assign blocked  = flt.priv_f | flt.sec_f;
    assign reg_wr   = m_req & m_we & ~blocked & to_self;

    assign p_req    = m_req & ~blocked & ~to_self;
    assign p_we     = p_req & m_we;
    assign p_pid    = m_pid;
    assign p_addr   = m_addr;
    assign p_wdata  = m_wdata;
    assign irq_priv = irq[FB_PRIV];
    assign irq_sec  = irq[FB_SEC];

    always_comb begin
        m_rdata = '0;
        if (m_req && !blocked && !m_we) m_rdata = to_self ? reg_rdata : p_rdata;
    end

    p_no_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flt.priv_f |-> !p_req && !p_we);

    p_zero_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> m_rdata == '0);

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !prot_en && !to_self |-> p_req && (p_we == m_we));

    p_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flt.sec_f |-> !p_we);

endmodule

// File: tb/sim_acc_guard.sv
`timescale 1ns/1ps
module sim_acc_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0, m_priv = 1'b0, m_sec = 1'b0;
    logic [5:0]  m_pid = '0;
    logic [3:0]  m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        p_req, p_we;
    logic [5:0]  p_pid;
    logic [3:0]  p_addr;
    logic [31:0] p_wdata;
    logic [31:0] p_rdata;
    logic        irq_priv, irq_sec;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic        s_preq, s_pwe;
    logic [31:0] s_rd;

    localparam int SELF = 45;

    always #2.5 clk = ~clk;

    assign p_rdata = 32'hA500_0000 | {26'd0, p_pid};

    acc_guard u0 (
        .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_priv(m_priv),
        .m_sec(m_sec), .m_pid(m_pid), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .p_req(p_req), .p_we(p_we), .p_pid(p_pid),
        .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
        .irq_priv(irq_priv), .irq_sec(irq_sec)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input int pid, input int addr, input bit we, input bit pv,
                       input bit sc, input logic [31:0] wd);
        @(negedge clk);
        m_req = 1'b1; m_we = we; m_priv = pv; m_sec = sc;
        m_pid = 6'(pid); m_addr = 4'(addr); m_wdata = wd;
        #1;
        s_preq = p_req; s_pwe = p_we; s_rd = m_rdata;
        @(posedge clk);
        #1;
        m_req = 1'b0; m_we = 1'b0;
    endtask

    task automatic reg_wr(input int addr, input logic [31:0] d);
        acc(SELF, addr, 1'b1, 1'b1, 1'b0, d);
    endtask

    task automatic reg_rd(input int addr, output logic [31:0] d);
        acc(SELF, addr, 1'b0, 1'b1, 1'b0, 32'd0);
        d = s_rd;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(irq_priv == 0 && irq_sec == 0, "R8 irq low at reset", {30'd0, irq_sec, irq_priv}, 0);
        reg_rd(0, d);  chk(d == 0, "R4 ctrl reset value", d, 0);
        reg_rd(5, d);  chk(d == 0, "R7 flags reset value", d, 0);
    endtask

    task automatic t_passthru();
        logic [31:0] d;
        reg_wr(1, 32'h0000_0008);
        acc(3, 2, 1'b0, 1'b0, 1'b1, 0);
        chk(s_preq == 1, "R4 pass with enable off", {31'd0, s_preq}, 1);
        chk(s_rd == 32'hA500_0003, "R4 read data passes", s_rd, 32'hA500_0003);
        reg_rd(5, d);  chk(d == 0, "R4 no fault when off", d, 0);
    endtask

    task automatic t_priv_block();
        logic [31:0] d;
        reg_wr(2, 32'h0000_0004);
        reg_wr(0, 32'h1);
        acc(3, 1, 1'b1, 1'b0, 1'b0, 32'hDEAD);
        chk(s_preq == 0, "R1 blocked write not forwarded", {31'd0, s_preq}, 0);
        chk(s_pwe == 0, "R12 no write strobe", {31'd0, s_pwe}, 0);
        reg_rd(5, d);  chk(d == 1, "R5 priv flag set", d, 1);
        reg_rd(10, d); chk(d == 3, "R5 fault id", d, 3);
        acc(34, 0, 1'b0, 1'b0, 1'b0, 0);
        chk(s_rd == 0, "R2 blocked read zero", s_rd, 0);
        chk(s_preq == 0, "R3 id 34 in second word", {31'd0, s_preq}, 0);
        reg_rd(10, d); chk(d == 3, "R7 first id kept", d, 3);
        acc(34, 0, 1'b0, 1'b1, 1'b0, 0);
        chk(s_rd == 32'hA500_0022, "R3 privileged passes", s_rd, 32'hA500_0022);
        acc(4, 0, 1'b0, 1'b0, 1'b0, 0);
        chk(s_preq == 1, "R3 unmarked id passes", {31'd0, s_preq}, 1);
        reg_wr(7, 32'h3);
        reg_rd(5, d);  chk(d == 0, "R9 clear mask", d, 0);
    endtask

    task automatic t_sec();
        logic [31:0] d;
        reg_wr(3, 32'h0000_0080);
        acc(7, 0, 1'b1, 1'b1, 1'b0, 32'h1);
        chk(s_pwe == 0, "R6 secure via nonsecure blocked", {31'd0, s_pwe}, 0);
        reg_rd(5, d);  chk(d == 2, "R6 sec flag", d, 2);
        reg_rd(10, d); chk(d == 7, "R6 fault id", d, 7);
        acc(8, 0, 1'b0, 1'b1, 1'b1, 0);
        chk(s_rd == 0, "R6 nonsecure via secure blocked", s_rd, 0);
        reg_rd(10, d); chk(d == 7, "R7 id held on second fault", d, 7);
        acc(7, 0, 1'b0, 1'b1, 1'b1, 0);
        chk(s_rd == 32'hA500_0007, "R6 matching alias passes", s_rd, 32'hA500_0007);
        reg_wr(7, 32'h3);
    endtask

    task automatic t_both();
        logic [31:0] d;
        acc(3, 0, 1'b1, 1'b0, 1'b1, 32'h5);
        chk(s_pwe == 0, "R10 double fault blocked", {31'd0, s_pwe}, 0);
        reg_rd(5, d);  chk(d == 3, "R10 both flags", d, 3);
        reg_rd(10, d); chk(d == 3, "R10 single id", d, 3);
        reg_wr(7, 32'h3);
        acc(12, 0, 1'b0, 1'b1, 1'b1, 0);
        reg_rd(10, d); chk(d == 12, "R7 new id after clear", d, 12);
        reg_wr(7, 32'h3);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        reg_wr(6, 32'h2);
        reg_rd(5, d);  chk(d == 2, "R9 set mask", d, 2);
        chk(irq_sec == 0, "R8 no irq while disabled", {31'd0, irq_sec}, 0);
        reg_wr(8, 32'h3);
        reg_rd(5, d);  chk(d == 2, "R9 enable keeps pending", d, 2);
        chk(irq_sec == 1 && irq_priv == 0, "R8 irq and", {30'd0, irq_sec, irq_priv}, 2);
        reg_rd(9, d);  chk(d == 2, "R8 pending and enabled", d, 2);
        reg_rd(5, d);  chk(d == 2, "R8 read does not clear", d, 2);
        reg_wr(8, 32'h1);
        reg_rd(9, d);  chk(d == 0, "R8 masked by enable", d, 0);
        reg_wr(7, 32'h2);
        acc(3, 0, 1'b0, 1'b0, 1'b0, 0);
        chk(irq_priv == 1, "R12 irq after fault edge", {31'd0, irq_priv}, 1);
        reg_wr(7, 32'h3);
    endtask

    task automatic t_self();
        logic [31:0] d;
        reg_wr(2, 32'h0000_2004);
        acc(SELF, 0, 1'b1, 1'b0, 1'b0, 32'h0);
        reg_rd(0, d);  chk(d == 1, "R11 blocked write kept config", d, 1);
        reg_rd(10, d); chk(d == SELF, "R11 self id captured", d, SELF);
        acc(SELF, 0, 1'b0, 1'b0, 1'b0, 0);
        chk(s_rd == 0, "R11 unprivileged read of self zero", s_rd, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_priv_block();
        t_sec();
        t_both();
        t_irq();
        t_self();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule